// File: doc/BRIEF.md
# Charge-Pump Gain and Thermal Protection Controller

This block decides the gain of an inductorless LED charge pump. The pump starts in pass mode (1x). Each main-display current sink has an analog comparator that reports when the voltage across the sink has fallen to about 175 mV. When an enabled, monitored sink reports this for long enough, the block moves the pump to 1.5x. The indicator sink never takes part in this decision. The sensing on the last main pin can be masked off by a configuration bit, for boards that leave that pin unused. A sink that is left floating reads as having too little headroom, so it holds the pump in 1.5x.

The block also gates the pump and the sinks. They turn off when both banks are disabled, and they turn off during a thermal shutdown. The thermal shutdown is driven by two flags: a "too hot" flag near 170 °C and a "cooled down" flag near 165 °C. Between the two thresholds the previous state is kept, which forms a hysteresis band. A move to 1.5x holds until the next shutdown or reset. After that, the pump restarts in 1x.

Top module: `cpg_ctrl`

## Requirements
- R1: A synchronous reset sets gain_sel, pump_en and drv_en to 0. In gain_sel, 0 means 1x and 1 means 1.5x.
- R2: At each clock edge, pump_en and drv_en are both set to 1 when en_main or en_aux is 1 and no thermal shutdown is in force. Otherwise both are set to 0.
- R3: gain_sel becomes 1 at the edge that samples the eighth consecutive cycle in which a monitored pin flag is high. Seven consecutive cycles leave gain_sel at 0.
- R4: A sampled cycle in which no monitored flag is high restarts the count. A cycle with pwm_on at 0 counts as such a cycle.
- R5: Pins are monitored only while en_main is 1. With only en_aux set, no flag pattern changes gain_sel.
- R6: Bit 4 of low_hr (the last pin) is monitored only when en_sense5 is 1. Bits 0 to 3 are monitored whenever en_main is 1.
- R7: Once gain_sel is 1, it stays 1 while the block stays enabled, even with every flag low. It returns to 0 at the edge where the block shuts down.
- R8: therm_hot starts a thermal shutdown at the next edge. The shutdown holds while both flags are 0. It ends at the edge that samples therm_cool high with therm_hot low. therm_hot wins when both flags are high.
- R9: A shutdown that is sampled at the same edge as the eighth qualifying sample wins. gain_sel stays 0, and counting starts again from zero after the block is re-enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| low_hr | input | 5 | Low-headroom flags of the main sink pins; bit 0 is the first pin |
| en_main | input | 1 | Main bank enable |
| en_aux | input | 1 | Indicator sink enable |
| en_sense5 | input | 1 | Enables sensing on the last main pin |
| pwm_on | input | 1 | Main bank PWM gate; 1 while the sinks conduct |
| therm_hot | input | 1 | Die above the upper thermal threshold |
| therm_cool | input | 1 | Die below the lower thermal threshold |
| gain_sel | output | 1 | Pump gain: 0 = 1x, 1 = 1.5x |
| pump_en | output | 1 | Pump oscillator enable |
| drv_en | output | 1 | Current-sink enable |

## Verification
The eighth consecutive low-headroom sample can arrive in the same cycle as a shutdown request. The request may come from a rising thermal flag or from the enables being cleared. The bench provokes this by holding a pin flag for seven edges and then raising therm_hot before the eighth edge. The result is judged on three things: gain_sel must stay at 1x, both enables must drop, and after cooling a fresh run of eight samples must be needed. The bench's behavioural model is compared with the outputs on every clock, so every other overlap of debounce, masking and hysteresis is covered as well.

// File: rtl/cpg_pkg.sv
package cpg_pkg;

    typedef enum logic {
        GAIN_1X   = 1'b0,
        GAIN_1P5X = 1'b1
    } gain_e;

    typedef struct packed {
        logic main_on;
        logic aux_on;
        logic last_sense;
    } en_cfg_t;

    function automatic logic is_shutdown(en_cfg_t c, logic ovh_next);
        return !(c.main_on || c.aux_on) || ovh_next;
    endfunction

endpackage

// File: rtl/cpg_thermal.sv
module cpg_thermal (
    input  logic clk,
    input  logic rst,
    input  logic hot,
    input  logic cool,
    output logic ovh_nxt
);
    logic ovh_q;

    // hot dominates; the band between thresholds keeps the last state
    assign ovh_nxt = hot || (ovh_q && !cool);

    always_ff @(posedge clk) begin
        if (rst) ovh_q <= 1'b0;
        else     ovh_q <= ovh_nxt;
    end
endmodule

// File: rtl/cpg_headroom_mon.sv
module cpg_headroom_mon
    import cpg_pkg::*;
#(
    parameter int NUM_PINS   = 5,
    parameter int DEB_CYCLES = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic [NUM_PINS-1:0] low,
    input  en_cfg_t             cfg,
    input  logic                pwm_on,
    output logic                trip
);
    localparam int CW = (DEB_CYCLES > 1) ? $clog2(DEB_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(DEB_CYCLES - 1);

    logic [NUM_PINS-1:0] mask;
    logic                any_low;
    logic [CW-1:0]       cnt_q;

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_mask
        if (i == NUM_PINS - 1) begin : g_last
            assign mask[i] = cfg.main_on && cfg.last_sense;
        end else begin : g_std
            assign mask[i] = cfg.main_on;
        end
    end

    assign any_low = pwm_on && |(low & mask);
    assign trip    = any_low && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr || !any_low) cnt_q <= '0;
        else if (cnt_q != LAST)     cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/cpg_ctrl.sv
module cpg_ctrl
    import cpg_pkg::*;
#(
    parameter int NUM_PINS   = 5,
    parameter int DEB_CYCLES = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] low_hr,
    input  logic                en_main,
    input  logic                en_aux,
    input  logic                en_sense5,
    input  logic                pwm_on,
    input  logic                therm_hot,
    input  logic                therm_cool,
    output logic                gain_sel,
    output logic                pump_en,
    output logic                drv_en
);
    en_cfg_t cfg;
    logic    ovh_nxt;
    logic    sd;
    logic    trip;
    gain_e   gain_q;
    logic    on_q;

    assign cfg = '{main_on: en_main, aux_on: en_aux, last_sense: en_sense5};

    cpg_thermal u_therm (
        .clk     (clk),
        .rst     (rst),
        .hot     (therm_hot),
        .cool    (therm_cool),
        .ovh_nxt (ovh_nxt)
    );

    assign sd = is_shutdown(cfg, ovh_nxt);

    cpg_headroom_mon #(
        .NUM_PINS   (NUM_PINS),
        .DEB_CYCLES (DEB_CYCLES)
    ) u_mon (
        .clk    (clk),
        .rst    (rst),
        .clr    (sd),
        .low    (low_hr),
        .cfg    (cfg),
        .pwm_on (pwm_on),
        .trip   (trip)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            gain_q <= GAIN_1X;
            on_q   <= 1'b0;
        end else begin
            on_q <= !sd;
            if (sd)        gain_q <= GAIN_1X;
            else if (trip) gain_q <= GAIN_1P5X;
        end
    end

    assign gain_sel = (gain_q == GAIN_1P5X);
    assign pump_en  = on_q;
    assign drv_en   = on_q;
endmodule

// File: rtl/cpg_ctrl_chk.sv
module cpg_ctrl_chk #(
    parameter int NUM_PINS   = 5,
    parameter int DEB_CYCLES = 8
) (
    input logic                clk,
    input logic                rst,
    input logic [NUM_PINS-1:0] low_hr,
    input logic                en_main,
    input logic                en_aux,
    input logic                en_sense5,
    input logic                pwm_on,
    input logic                therm_hot,
    input logic                therm_cool,
    input logic                gain_sel,
    input logic                pump_en,
    input logic                drv_en
);
    logic mon;
    int   run_q;

    assign mon = pwm_on && en_main &&
                 ((|low_hr[NUM_PINS-2:0]) || (low_hr[NUM_PINS-1] && en_sense5));

    always_ff @(posedge clk) begin
        if (rst)                     run_q <= 0;
        else if (!mon)               run_q <= 0;
        else if (run_q < DEB_CYCLES) run_q <= run_q + 1;
    end

    p_idle_off_r2: assert property (@(posedge clk) disable iff (rst)
        (!en_main && !en_aux) |=> (!drv_en && !pump_en));

    p_hot_off_r8: assert property (@(posedge clk) disable iff (rst)
        therm_hot |=> (!drv_en && !pump_en));

    p_cool_on_r8: assert property (@(posedge clk) disable iff (rst)
        (therm_cool && !therm_hot && (en_main || en_aux)) |=> drv_en);

    p_debounce_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(gain_sel) |-> (run_q >= DEB_CYCLES));

    p_main_only_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(gain_sel) |-> $past(en_main));

    p_boost_when_on_r7: assert property (@(posedge clk) disable iff (rst)
        gain_sel |-> drv_en);

    p_drop_on_off_r7: assert property (@(posedge clk) disable iff (rst)
        (!en_main && !en_aux) |=> !gain_sel);
endmodule

bind cpg_ctrl cpg_ctrl_chk #(
    .NUM_PINS   (NUM_PINS),
    .DEB_CYCLES (DEB_CYCLES)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .low_hr     (low_hr),
    .en_main    (en_main),
    .en_aux     (en_aux),
    .en_sense5  (en_sense5),
    .pwm_on     (pwm_on),
    .therm_hot  (therm_hot),
    .therm_cool (therm_cool),
    .gain_sel   (gain_sel),
    .pump_en    (pump_en),
    .drv_en     (drv_en)
);

// File: tb/cpg_ctrl_tb.sv
module cpg_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NP  = 5;
    localparam int DEB = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NP-1:0] low_hr = '0;
    logic          en_main = 1'b0, en_aux = 1'b0, en_sense5 = 1'b0;
    logic          pwm_on = 1'b0, therm_hot = 1'b0, therm_cool = 1'b0;
    logic          gain_sel, pump_en, drv_en;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit cmp_on = 0;

    // behavioural reference state
    int m_ovh = 0, m_on = 0, m_gain = 0, m_run = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpg_ctrl #(.NUM_PINS(NP), .DEB_CYCLES(DEB)) u_dut (
        .clk(clk), .rst(rst), .low_hr(low_hr), .en_main(en_main),
        .en_aux(en_aux), .en_sense5(en_sense5), .pwm_on(pwm_on),
        .therm_hot(therm_hot), .therm_cool(therm_cool),
        .gain_sel(gain_sel), .pump_en(pump_en), .drv_en(drv_en)
    );

    always @(posedge clk) begin
        int hot_n;
        int seen;
        int off;
        seen = 0;
        for (int p = 0; p < NP; p++) begin
            if (low_hr[p] && en_main && (p < NP - 1 || en_sense5)) seen = 1;
        end
        if (!pwm_on) seen = 0;
        hot_n = (therm_hot || (m_ovh != 0 && !therm_cool)) ? 1 : 0;
        off   = (!(en_main || en_aux) || hot_n != 0) ? 1 : 0;
        if (rst) begin
            m_ovh = 0; m_on = 0; m_gain = 0; m_run = 0;
        end else begin
            m_ovh = hot_n;
            m_on  = off ? 0 : 1;
            if (off) begin
                m_gain = 0; m_run = 0;
            end else if (seen) begin
                m_run++;
                if (m_run >= DEB) m_gain = 1;
            end else begin
                m_run = 0;
            end
        end
        if (rst) cmp_on = 1;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on && !done) begin
            check(gain_sel === 1'(m_gain), "model gain R3 R7 R9", int'(gain_sel), m_gain);
            check(drv_en === 1'(m_on), "model drv_en R2 R8", int'(drv_en), m_on);
            check(pump_en === 1'(m_on), "model pump_en R2 R8", int'(pump_en), m_on);
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_out(input string tag, input int g, input int d);
        check(gain_sel === 1'(g), tag, int'(gain_sel), g);
        check(drv_en === 1'(d) && pump_en === 1'(d), tag, int'(drv_en), d);
    endtask

    task automatic rearm();
        low_hr = '0; en_main = 1'b0; step(1);
        en_main = 1'b1; step(1);
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        step(3);
        expect_out("R1 reset", 0, 0);
        rst = 1'b0;
        // R2 enable
        en_main = 1'b1; pwm_on = 1'b1; en_sense5 = 1'b1;
        step(1); expect_out("R2 enable", 0, 1);
        // R3 debounce
        low_hr = 5'b00010; step(7); expect_out("R3 seven samples", 0, 1);
        step(1); expect_out("R3 eighth sample", 1, 1);
        // R7 sticky, then drop
        low_hr = '0; step(3); expect_out("R7 sticky", 1, 1);
        en_main = 1'b0; step(1); expect_out("R7 R2 disable", 0, 0);
        en_main = 1'b1; step(1); expect_out("R7 restart 1x", 0, 1);
        // R4 flag gap
        low_hr = 5'b00001; step(5); low_hr = '0; step(1);
        low_hr = 5'b00001; step(7); expect_out("R4 gap restart", 0, 1);
        step(1); expect_out("R4 after gap", 1, 1);
        rearm();
        // R4 PWM gate off
        low_hr = 5'b00100; step(4); pwm_on = 1'b0; step(1); pwm_on = 1'b1;
        step(7); expect_out("R4 gate restart", 0, 1);
        step(1); expect_out("R4 after gate", 1, 1);
        rearm();
        // R6 last pin mask
        en_sense5 = 1'b0; low_hr = 5'b10000; step(10);
        expect_out("R6 masked", 0, 1);
        en_sense5 = 1'b1; step(7); expect_out("R6 unmasked 7", 0, 1);
        step(1); expect_out("R6 unmasked 8", 1, 1);
        rearm();
        // R5 aux only
        en_main = 1'b0; en_aux = 1'b1; low_hr = 5'b11111; step(12);
        expect_out("R5 aux only", 0, 1);
        // R8 thermal hysteresis
        en_main = 1'b1; low_hr = '0; step(2);
        therm_hot = 1'b1; step(1); expect_out("R8 hot", 0, 0);
        therm_hot = 1'b0; step(3); expect_out("R8 band", 0, 0);
        therm_cool = 1'b1; step(1); expect_out("R8 cool", 0, 1);
        therm_hot = 1'b1; step(1); expect_out("R8 both", 0, 0);
        therm_hot = 1'b0; step(1); expect_out("R8 recover", 0, 1);
        therm_cool = 1'b0; en_aux = 1'b0;
        // R9 same-cycle shutdown and trip
        low_hr = 5'b00001; step(7); expect_out("R9 pre", 0, 1);
        therm_hot = 1'b1; step(1); expect_out("R9 collide", 0, 0);
        therm_hot = 1'b0; therm_cool = 1'b1; step(1); expect_out("R9 cooled", 0, 1);
        therm_cool = 1'b0; step(6); expect_out("R9 count restarted", 0, 1);
        step(1); expect_out("R9 new trip", 1, 1);
        // R1 reset while boosted
        rst = 1'b1; step(1); expect_out("R1 reset mid-run", 0, 0);
        rst = 1'b0; step(2);
        finish_run();
    end
endmodule